// File: doc/BRIEF.md
# Configuration Header Target for One Device Function

This block answers configuration reads and writes aimed at the fixed 16-dword header of a single device function. A request names a dword index from 0 to 15, raises a read strobe or a write strobe, and for writes supplies four byte enables and 32 bits of data. Read data comes back registered, one clock after the read strobe, together with a valid flag.

The header carries fixed identification fields. It also holds a small set of software-writable fields: the command bits, the cache line size, the latency timer and the interrupt line. Six base-address slots follow the identification fields. Each slot is set by parameter to one of four kinds: absent, I/O, 32-bit memory, or 32-bit prefetchable memory. Each present slot also has a size given as a power of two.

A present slot reports its kind in its low bits. It keeps only the address bits at or above its size. Software finds the size of a region by writing all ones to the slot and reading it back.

Top module: `cfg_hdr_target`

## Requirements
- R1: A read strobe in cycle N gives rsp_valid=1 and the read data in cycle N+1. In any cycle that follows a cycle with no read strobe, rsp_valid=0 and rsp_rdata=0.
- R2: Dword 0 reads {DEVICE_ID, VENDOR_ID}, with the vendor ID in bits 15:0. Dword 2 reads {CLASS_CODE, REVISION_ID}, with the revision ID in bits 7:0. Writes to both dwords are ignored.
- R3: In dword 1, bits 15:0 are the command field. Only the bits set in 0x0547 can be written; the other command bits read 0. Bits 31:16 always read the STATUS_VAL parameter.
- R4: In dword 3, byte 0 (cache line size) and byte 1 (latency timer) can be written. Byte 2 (header type) and byte 3 (self-test) read 0x00, and writes to them are ignored.
- R5: An I/O slot reads bit 0 = 1 and bit 1 = 0. A memory slot reads bit 0 = 0 and bits 2:1 = 00 (32-bit decode). Bit 3 reads 1 only in a prefetchable memory slot.
- R6: Write all ones to a present slot of size 2^S, then read it back. The result has ones in bits 31:S, zeros in the address bits below S, and the type bits of R5.
- R7: A write to a present slot changes only bits 31:S. A later read returns the written upper bits together with the type bits.
- R8: A write changes only the bytes whose enable bit is 1 (be[k] covers bits 8k+7:8k), and only the writable bits inside those bytes.
- R9: Absent slots and dwords 10 to 14 read zero, and writes to them are ignored.
- R10: In dword 15, byte 0 (interrupt line) can be written. Bytes 1, 2 and 3 read INT_PIN, MIN_GRANT and MAX_LATENCY, and writes to them are ignored.
- R11: After reset, every writable field reads zero.
- R12: A read and a write in the same cycle return the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| req_idx | input | 4 | Header dword index |
| req_be | input | 4 | Byte enables for writes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after req_rd |
| rsp_rdata | output | 32 | Read data |

## Verification
Every stored field is visible through a read, and a read answers on the next clock. A wrong write mask, a lost byte enable or a corrupted base address therefore shows up on rsp_rdata on the first read of that dword after the faulty write. The bench runs a behavioural model of all 16 dwords and reads back after directed writes and random traffic. A bad stored bit is therefore caught within the few cycles before that dword is read again. Errors in the size or type encoding show up at once in the all-ones probe readback.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

    localparam int DW_W      = 32;
    localparam int IDX_W     = 4;
    localparam int BE_W      = DW_W / 8;
    localparam int NUM_BARS  = 6;
    localparam int BAR_FIRST = 4;
    localparam int KIND_W    = 2;
    localparam int SIZE_W    = 5;

    localparam logic [IDX_W-1:0] IDX_IDENT = 4'd0;
    localparam logic [IDX_W-1:0] IDX_CMD   = 4'd1;
    localparam logic [IDX_W-1:0] IDX_CLASS = 4'd2;
    localparam logic [IDX_W-1:0] IDX_MISC  = 4'd3;
    localparam logic [IDX_W-1:0] IDX_IRQ   = 4'd15;

    localparam logic [15:0] CMD_WMASK = 16'h0547;

    typedef enum logic [KIND_W-1:0] {
        SLOT_ABSENT = 2'd0,
        SLOT_IO     = 2'd1,
        SLOT_MEM    = 2'd2,
        SLOT_MEM_PF = 2'd3
    } slot_kind_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [IDX_W-1:0]  idx;
        logic [BE_W-1:0]   be;
        logic [DW_W-1:0]   wdata;
    } cfg_req_t;

    typedef struct packed {
        logic [15:0] cmd;
        logic [7:0]  cache_line;
        logic [7:0]  lat_timer;
        logic [7:0]  irq_line;
    } ctrl_state_t;

    function automatic logic [DW_W-1:0] be_expand(input logic [BE_W-1:0] be);
        logic [DW_W-1:0] m;
        for (int b = 0; b < BE_W; b++) begin
            m[8*b +: 8] = {8{be[b]}};
        end
        return m;
    endfunction

    function automatic logic [3:0] kind_low_bits(input slot_kind_e k);
        case (k)
            SLOT_IO:     return 4'b0001;
            SLOT_MEM:    return 4'b0000;
            SLOT_MEM_PF: return 4'b1000;
            default:     return 4'b0000;
        endcase
    endfunction

    function automatic int min_size(input slot_kind_e k);
        return (k == SLOT_IO) ? 2 : 4;
    endfunction

endpackage

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot
    import cfg_hdr_pkg::*;
#(
    parameter slot_kind_e KIND    = SLOT_MEM,
    parameter int         SIZE_L2 = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [BE_W-1:0]      be,
    input  logic [DW_W-1:0]      wdata,
    output logic [DW_W-1:0]      rdata
);
    localparam int EFF_L2 = (SIZE_L2 < min_size(KIND)) ? min_size(KIND) : SIZE_L2;
    localparam logic [DW_W-1:0] ADDR_MASK = ~((32'd1 << EFF_L2) - 32'd1);
    localparam logic [3:0] LOW = kind_low_bits(KIND);

    generate
        if (KIND == SLOT_ABSENT) begin : g_absent
            assign rdata = '0;
        end else begin : g_present
            logic [DW_W-1:0] base_q;
            logic [DW_W-1:0] wmask;

            assign wmask = be_expand(be) & ADDR_MASK;

            always_ff @(posedge clk) begin
                if (rst) begin
                    base_q <= '0;
                end else if (wr_en) begin
                    base_q <= (base_q & ~wmask) | (wdata & wmask);
                end
            end

            assign rdata = (base_q & ADDR_MASK) | {28'd0, LOW};
        end
    endgenerate

endmodule

// File: rtl/cfg_ctrl_regs.sv
module cfg_ctrl_regs
    import cfg_hdr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  cfg_req_t    req,
    output ctrl_state_t st
);
    logic [DW_W-1:0] bm;
    assign bm = be_expand(req.be);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (req.wr) begin
            case (req.idx)
                IDX_CMD: begin
                    st.cmd <= (st.cmd & ~(bm[15:0] & CMD_WMASK))
                            | (req.wdata[15:0] & bm[15:0] & CMD_WMASK);
                end
                IDX_MISC: begin
                    if (req.be[0]) st.cache_line <= req.wdata[7:0];
                    if (req.be[1]) st.lat_timer  <= req.wdata[15:8];
                end
                IDX_IRQ: begin
                    if (req.be[0]) st.irq_line <= req.wdata[7:0];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cfg_hdr_target.sv
module cfg_hdr_target
    import cfg_hdr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID   = 16'hAB12,
    parameter logic [15:0] DEVICE_ID   = 16'hC0DE,
    parameter logic [7:0]  REVISION_ID = 8'h03,
    parameter logic [23:0] CLASS_CODE  = 24'h020000,
    parameter logic [15:0] STATUS_VAL  = 16'h0200,
    parameter logic [7:0]  INT_PIN     = 8'h01,
    parameter logic [7:0]  MIN_GRANT   = 8'h04,
    parameter logic [7:0]  MAX_LATENCY = 8'h10,
    parameter logic [NUM_BARS*KIND_W-1:0] BAR_KINDS =
        {2'd0, 2'd0, 2'd3, 2'd1, 2'd0, 2'd2},
    parameter logic [NUM_BARS*SIZE_W-1:0] BAR_SIZES =
        {5'd0, 5'd0, 5'd12, 5'd5, 5'd0, 5'd17}
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_rd,
    input  logic        req_wr,
    input  logic [3:0]  req_idx,
    input  logic [3:0]  req_be,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata
);
    cfg_req_t        req;
    ctrl_state_t     ctrl;
    logic [DW_W-1:0] bar_rd [NUM_BARS];
    logic [DW_W-1:0] rd_mux;

    assign req = '{rd: req_rd, wr: req_wr, idx: req_idx, be: req_be, wdata: req_wdata};

    cfg_ctrl_regs u_ctrl (
        .clk (clk),
        .rst (rst),
        .req (req),
        .st  (ctrl)
    );

    for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
        localparam slot_kind_e K = slot_kind_e'(BAR_KINDS[KIND_W*i +: KIND_W]);
        localparam int         S = int'(BAR_SIZES[SIZE_W*i +: SIZE_W]);
        logic sel_wr;
        assign sel_wr = req.wr && (req.idx == IDX_W'(BAR_FIRST + i));
        cfg_bar_slot #(.KIND(K), .SIZE_L2(S)) u_slot (
            .clk   (clk),
            .rst   (rst),
            .wr_en (sel_wr),
            .be    (req.be),
            .wdata (req.wdata),
            .rdata (bar_rd[i])
        );
    end

    always_comb begin
        rd_mux = '0;
        case (req.idx)
            IDX_IDENT: rd_mux = {DEVICE_ID, VENDOR_ID};
            IDX_CMD:   rd_mux = {STATUS_VAL, ctrl.cmd};
            IDX_CLASS: rd_mux = {CLASS_CODE, REVISION_ID};
            IDX_MISC:  rd_mux = {16'h0000, ctrl.lat_timer, ctrl.cache_line};
            4'd4:      rd_mux = bar_rd[0];
            4'd5:      rd_mux = bar_rd[1];
            4'd6:      rd_mux = bar_rd[2];
            4'd7:      rd_mux = bar_rd[3];
            4'd8:      rd_mux = bar_rd[4];
            4'd9:      rd_mux = bar_rd[5];
            IDX_IRQ:   rd_mux = {MAX_LATENCY, MIN_GRANT, INT_PIN, ctrl.irq_line};
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req.rd;
            rsp_rdata <= req.rd ? rd_mux : '0;
        end
    end

endmodule

// File: rtl/cfg_hdr_chk.sv
module cfg_hdr_chk
    import cfg_hdr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID   = 16'h0,
    parameter logic [15:0] DEVICE_ID   = 16'h0,
    parameter logic [15:0] STATUS_VAL  = 16'h0,
    parameter logic [7:0]  INT_PIN     = 8'h0,
    parameter logic [7:0]  MIN_GRANT   = 8'h0,
    parameter logic [7:0]  MAX_LATENCY = 8'h0,
    parameter logic [NUM_BARS*KIND_W-1:0] BAR_KINDS = '0
) (
    input logic        clk,
    input logic        rst,
    input logic        req_rd,
    input logic [3:0]  req_idx,
    input logic        rsp_valid,
    input logic [31:0] rsp_rdata
);
    logic       bar_hit;
    logic [3:0] bar_low;
    logic       bar_absent;
    int         slot;

    always_comb begin
        slot       = int'(req_idx) - BAR_FIRST;
        bar_hit    = (req_idx >= 4'd4) && (req_idx <= 4'd9);
        bar_low    = 4'd0;
        bar_absent = 1'b0;
        if (bar_hit) begin
            bar_low    = kind_low_bits(slot_kind_e'(BAR_KINDS[KIND_W*slot +: KIND_W]));
            bar_absent = slot_kind_e'(BAR_KINDS[KIND_W*slot +: KIND_W]) == SLOT_ABSENT;
        end
    end

    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (rst)
        req_rd |=> rsp_valid);  // R1
    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req_rd |=> (!rsp_valid && rsp_rdata == 32'd0));  // R1
    AST_IDENT_CONST: assert property (@(posedge clk) disable iff (rst)
        (req_rd && req_idx == 4'd0) |=> rsp_rdata == {DEVICE_ID, VENDOR_ID});  // R2
    AST_STATUS_CONST: assert property (@(posedge clk) disable iff (rst)
        (req_rd && req_idx == 4'd1) |=> rsp_rdata[31:16] == STATUS_VAL);  // R3
    AST_HDR_TYPE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (req_rd && req_idx == 4'd3) |=> rsp_rdata[31:16] == 16'h0000);  // R4
    AST_BAR_TYPE_BITS: assert property (@(posedge clk) disable iff (rst)
        (req_rd && bar_hit) |=> rsp_rdata[3:0] == $past(bar_low));  // R5
    AST_ABSENT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (req_rd && bar_hit && bar_absent) |=> rsp_rdata == 32'd0);  // R9
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (req_rd && req_idx >= 4'd10 && req_idx <= 4'd14) |=> rsp_rdata == 32'd0);  // R9
    AST_IRQ_FIXED: assert property (@(posedge clk) disable iff (rst)
        (req_rd && req_idx == 4'd15) |=> rsp_rdata[31:8] == {MAX_LATENCY, MIN_GRANT, INT_PIN});  // R10

endmodule

bind cfg_hdr_target cfg_hdr_chk #(
    .VENDOR_ID   (VENDOR_ID),
    .DEVICE_ID   (DEVICE_ID),
    .STATUS_VAL  (STATUS_VAL),
    .INT_PIN     (INT_PIN),
    .MIN_GRANT   (MIN_GRANT),
    .MAX_LATENCY (MAX_LATENCY),
    .BAR_KINDS   (BAR_KINDS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_rd    (req_rd),
    .req_idx   (req_idx),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
);

// File: tb/cfg_hdr_target_tb.sv
module cfg_hdr_target_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_rd = 1'b0;
    logic        req_wr = 1'b0;
    logic [3:0]  req_idx = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Behavioural model: per dword a fixed part, a writable mask and stored bits.
    logic [31:0] fixed_v [16];
    logic [31:0] wmask_v [16];
    logic [31:0] store_v [16];
    logic        exp_valid;
    logic [31:0] exp_data;
    string       exp_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_hdr_target dut_i (
        .clk(clk), .rst(rst), .req_rd(req_rd), .req_wr(req_wr),
        .req_idx(req_idx), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    function automatic string tag_of(input int idx);
        case (idx)
            0, 2:          return "R2";
            1:             return "R3";
            3:             return "R4";
            4, 6, 7:       return "R7";
            15:            return "R10";
            default:       return "R9";
        endcase
    endfunction

    function automatic logic [31:0] model_read(input int idx);
        return fixed_v[idx] | (store_v[idx] & wmask_v[idx]);
    endfunction

    task automatic model_init();
        for (int i = 0; i < 16; i++) begin
            fixed_v[i] = 32'h0; wmask_v[i] = 32'h0; store_v[i] = 32'h0;
        end
        fixed_v[0]  = 32'hC0DEAB12;
        fixed_v[1]  = 32'h02000000; wmask_v[1]  = 32'h00000547;
        fixed_v[2]  = 32'h02000003;
        wmask_v[3]  = 32'h0000FFFF;
        wmask_v[4]  = 32'hFFFE0000;               // 128 KiB memory
        fixed_v[6]  = 32'h00000001; wmask_v[6] = 32'hFFFFFFE0; // 32 B I/O
        fixed_v[7]  = 32'h00000008; wmask_v[7] = 32'hFFFFF000; // 4 KiB prefetchable
        fixed_v[15] = 32'h10040100; wmask_v[15] = 32'h000000FF;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // One request cycle; compares the response one clock later.
    task automatic step(input bit rd, input bit wr, input int idx,
                        input logic [3:0] be, input logic [31:0] wd, input string tag);
        logic [31:0] bm;
        req_rd = rd; req_wr = wr; req_idx = idx[3:0]; req_be = be; req_wdata = wd;
        exp_valid = rd;
        exp_data  = rd ? model_read(idx) : 32'h0;   // R12: read sees old contents
        exp_tag   = tag;
        if (wr) begin
            for (int b = 0; b < 4; b++) bm[8*b +: 8] = {8{be[b]}};
            store_v[idx] = (store_v[idx] & ~bm) | (wd & bm);
        end
        @(posedge clk);
        @(negedge clk);
        check({exp_tag, " valid"}, {31'd0, rsp_valid}, {31'd0, exp_valid});
        check({exp_tag, " data"}, rsp_rdata, exp_data);
    endtask

    task automatic rd_chk(input int idx, input string tag);
        step(1'b1, 1'b0, idx, 4'h0, 32'h0, tag);
    endtask

    task automatic wr_only(input int idx, input logic [3:0] be, input logic [31:0] wd);
        step(1'b0, 1'b1, idx, be, wd, "R1");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        model_init();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 valid after reset", {31'd0, rsp_valid}, 32'd0);
        check("R11 data after reset", rsp_rdata, 32'd0);
        for (int i = 0; i < 16; i++) rd_chk(i, "R11");

        // R1: idle cycle after a read
        step(1'b0, 1'b0, 0, 4'h0, 32'h0, "R1");

        // R2 / R9: writes to read-only dwords ignored
        wr_only(0, 4'hF, 32'hFFFFFFFF); rd_chk(0, "R2");
        wr_only(2, 4'hF, 32'h0); rd_chk(2, "R2");
        for (int i = 10; i < 15; i++) begin wr_only(i, 4'hF, 32'hFFFFFFFF); rd_chk(i, "R9"); end
        wr_only(5, 4'hF, 32'hFFFFFFFF); rd_chk(5, "R9");
        wr_only(8, 4'hF, 32'hFFFFFFFF); rd_chk(8, "R9");
        wr_only(9, 4'hF, 32'hFFFFFFFF); rd_chk(9, "R9");

        // R3: command write mask, status fixed
        wr_only(1, 4'hF, 32'hFFFFFFFF); rd_chk(1, "R3");
        check("R3 cmd bits", {16'h0, rsp_rdata[15:0]}, 32'h00000547);

        // R4: cache line / latency, header type read-only
        wr_only(3, 4'hF, 32'hA5A55A3C); rd_chk(3, "R4");
        check("R4 misc", rsp_rdata, 32'h00005A3C);

        // R5 / R6: size probes
        wr_only(4, 4'hF, 32'hFFFFFFFF); rd_chk(4, "R6");
        check("R6 mem probe", rsp_rdata, 32'hFFFE0000);
        wr_only(6, 4'hF, 32'hFFFFFFFF); rd_chk(6, "R6");
        check("R5 io probe", rsp_rdata, 32'hFFFFFFE1);
        wr_only(7, 4'hF, 32'hFFFFFFFF); rd_chk(7, "R6");
        check("R5 prefetch probe", rsp_rdata, 32'hFFFFF008);

        // R7: base program stores upper bits only
        wr_only(4, 4'hF, 32'hE823FFFF); rd_chk(4, "R7");
        check("R7 mem base", rsp_rdata, 32'hE8220000);
        wr_only(6, 4'hF, 32'h0000501F); rd_chk(6, "R7");
        check("R7 io base", rsp_rdata, 32'h00005001);

        // R8: partial byte enables
        wr_only(4, 4'b0100, 32'h00770000); rd_chk(4, "R8");
        check("R8 byte2 only", rsp_rdata, 32'hE8760000);
        wr_only(3, 4'b0010, 32'h0000BB00); rd_chk(3, "R8");
        check("R8 latency only", rsp_rdata, 32'h0000BB3C);
        wr_only(1, 4'b0001, 32'h00000000); rd_chk(1, "R8");
        check("R8 cmd low byte", rsp_rdata, 32'h02000500);

        // R10: interrupt dword
        wr_only(15, 4'hF, 32'h00000000); rd_chk(15, "R10");
        check("R10 irq", rsp_rdata, 32'h10040100);
        wr_only(15, 4'b0001, 32'hFFFFFF2B); rd_chk(15, "R10");
        check("R10 line", rsp_rdata, 32'h1004012B);

        // R12: read and write together
        step(1'b1, 1'b1, 7, 4'hF, 32'h12345678, "R12");
        rd_chk(7, "R12");
        check("R12 after", rsp_rdata, 32'h12345008);

        // Random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            int idx;
            idx = int'($urandom_range(0, 15));
            step(1'($urandom), 1'($urandom), idx, 4'($urandom), $urandom, tag_of(idx));
        end

        // R11: reset clears writable fields again
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        model_init();
        @(negedge clk);
        for (int i = 0; i < 16; i++) rd_chk(i, "R11");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule